// File: doc/BRIEF.md
# Glitch-free 10-bit PWM with interlocked duty update

This block generates a single pulse-width-modulated output with 10 bits of duty resolution while being programmed over an 8-bit write port. The free-running time base is an 8-bit count extended by two sub-bits that advance every clock. The cycle length is set by an 8-bit period register. The duty value cannot be written in one access, so it is split into a high byte and a separate 2-bit low field.

Every write lands in a pending copy. The pending duty and period move into the active registers only when the time base rolls over, so a cycle that is already running is never cut short or stretched. Writing the high byte first arms an interlock. While it is armed, rollovers leave the active duty unchanged, and it is released when the matching low field is written. A torn value, with one half new and the other old, therefore never reaches the comparator. When the low field is written first within a cycle, the following high write completes the pair and no interlock is armed.

Software writes the period register, then the duty parts, and may write the timer register to end a cycle early.

Top module: `pwm10_interlock`

## Requirements
- R1: While `rst_n` is low, every register clears (period 0, duty 0, count 0, interlock idle) and `pwm_out` is low.
- R2: The 10-bit count rises by one each clock. At {active period, 2'b11} it wraps to 0 (a rollover), so a cycle lasts 4*(P+1) clocks.
- R3: `pwm_out` is high exactly when the count is below the active 10-bit duty. A duty of 0 keeps it low for the whole cycle, and a duty of at least 4*(P+1) keeps it high for the whole cycle.
- R4: Duty writes (select 1 = high byte `wr_data[7:0]`, select 2 = low field `wr_data[1:0]`) change only the pending value. The active duty = {high, low} is loaded at a rollover, using the pending contents from before any write in that same clock.
- R5: A period write (select 0) takes effect at the next rollover, together with the duty transfer.
- R6: A timer write (select 3) whose data equals the active period causes a rollover at that edge, and the count becomes 0. Any other data loads the count with {data, 2'b00}.
- R7: A high-byte write that is not completing a low-first pair arms the interlock. While it is armed, each rollover keeps the previous active duty. The next low-field write disarms it, and the next rollover transfers the complete pair.
- R8: A low-field write with the interlock idle marks a low-first pair. A high-byte write before the next rollover then completes the pair without arming. A rollover clears the mark.
- R9: When each duty update is written high byte first, alternating 00000001_00 and 00000000_11 never gives a cycle with 7 or 0 high clocks; every cycle has 3 or 4.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Write strobe, one register per clock |
| wr_sel | input | 2 | Register select: 0 period, 1 duty high, 2 duty low, 3 timer |
| wr_data | input | 8 | Write data |
| pwm_out | output | 1 | PWM output |

## Verification
The bench builds the block with its default 8-bit high byte and 2-bit low field. It programs periods of 1 to 3, so that rollovers occur every 8 to 16 clocks. These short periods bring many transfers into a short run: duty at both extremes, writes landing on the rollover edge itself, interlocks held across several rollovers, and the alternating torn-value sequence with the write offset swept across every position in the cycle.

// File: rtl/pwm10_pkg.sv
package pwm10_pkg;
  typedef enum logic [1:0] {
    SEL_PERIOD  = 2'd0,
    SEL_DUTY_HI = 2'd1,
    SEL_DUTY_LO = 2'd2,
    SEL_TIMER   = 2'd3
  } wr_sel_e;
endpackage

// File: rtl/pwm10_timebase.sv
module pwm10_timebase #(
  parameter int HI_W = 8,
  parameter int LO_W = 2,
  localparam int CNT_W = HI_W + LO_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              per_wr,
  input  logic              tmr_wr,
  input  logic [HI_W-1:0]   wr_data,
  output logic [CNT_W-1:0]  cnt,
  output logic [HI_W-1:0]   per_act,
  output logic              roll
);
  logic [HI_W-1:0]  per_pend;
  logic [CNT_W-1:0] cnt_end;

  assign cnt_end = {per_act, {LO_W{1'b1}}};

  // An early timer write that matches the period ends the cycle now.
  always_comb begin
    if (tmr_wr) roll = (wr_data == per_act);
    else        roll = (cnt == cnt_end);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt      <= '0;
      per_act  <= '0;
      per_pend <= '0;
    end else begin
      if (roll)        cnt <= '0;
      else if (tmr_wr) cnt <= {wr_data, {LO_W{1'b0}}};
      else             cnt <= cnt + 1'b1;
      if (roll)   per_act  <= per_pend;
      if (per_wr) per_pend <= wr_data;
    end
  end
endmodule

// File: rtl/pwm10_duty_buf.sv
module pwm10_duty_buf #(
  parameter int HI_W = 8,
  parameter int LO_W = 2,
  localparam int CNT_W = HI_W + LO_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              hi_wr,
  input  logic              lo_wr,
  input  logic [HI_W-1:0]   wr_data,
  input  logic              roll,
  output logic [CNT_W-1:0]  duty_act,
  output logic              armed
);
  logic [HI_W-1:0] hi_pend;
  logic [LO_W-1:0] lo_pend;
  logic            lo_first;
  logic            armed_nx;
  logic            lo_first_nx;

  // Pair tracking: high-first arms, low-first marks; the partner closes.
  always_comb begin
    armed_nx    = armed;
    lo_first_nx = roll ? 1'b0 : lo_first;
    if (hi_wr) begin
      if (lo_first) lo_first_nx = 1'b0;
      else          armed_nx    = 1'b1;
    end
    if (lo_wr) begin
      if (armed) armed_nx    = 1'b0;
      else       lo_first_nx = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hi_pend  <= '0;
      lo_pend  <= '0;
      duty_act <= '0;
      armed    <= 1'b0;
      lo_first <= 1'b0;
    end else begin
      if (roll && !armed) duty_act <= {hi_pend, lo_pend};
      if (hi_wr) hi_pend <= wr_data;
      if (lo_wr) lo_pend <= wr_data[LO_W-1:0];
      armed    <= armed_nx;
      lo_first <= lo_first_nx;
    end
  end
endmodule

// File: rtl/pwm10_compare.sv
module pwm10_compare #(
  parameter int CNT_W = 10
) (
  input  logic [CNT_W-1:0] cnt,
  input  logic [CNT_W-1:0] duty_act,
  output logic             pwm_out
);
  // Both operands are register outputs, so the compare has no torn input.
  assign pwm_out = (cnt < duty_act);
endmodule

// File: rtl/pwm10_interlock.sv
module pwm10_interlock #(
  parameter int HI_W = 8,
  parameter int LO_W = 2
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            wr_en,
  input  logic [1:0]      wr_sel,
  input  logic [HI_W-1:0] wr_data,
  output logic            pwm_out
);
  import pwm10_pkg::*;
  localparam int CNT_W = HI_W + LO_W;

  logic             per_wr, hi_wr, lo_wr, tmr_wr;
  logic [CNT_W-1:0] cnt;
  logic [CNT_W-1:0] duty_act;
  logic [HI_W-1:0]  per_act;
  logic             roll;
  logic             armed;

  assign per_wr = wr_en && (wr_sel == SEL_PERIOD);
  assign hi_wr  = wr_en && (wr_sel == SEL_DUTY_HI);
  assign lo_wr  = wr_en && (wr_sel == SEL_DUTY_LO);
  assign tmr_wr = wr_en && (wr_sel == SEL_TIMER);

  pwm10_timebase #(.HI_W(HI_W), .LO_W(LO_W)) u_tb (
    .clk(clk), .rst_n(rst_n), .per_wr(per_wr), .tmr_wr(tmr_wr),
    .wr_data(wr_data), .cnt(cnt), .per_act(per_act), .roll(roll)
  );

  pwm10_duty_buf #(.HI_W(HI_W), .LO_W(LO_W)) u_buf (
    .clk(clk), .rst_n(rst_n), .hi_wr(hi_wr), .lo_wr(lo_wr),
    .wr_data(wr_data), .roll(roll), .duty_act(duty_act), .armed(armed)
  );

  pwm10_compare #(.CNT_W(CNT_W)) u_cmp (
    .cnt(cnt), .duty_act(duty_act), .pwm_out(pwm_out)
  );
endmodule

// File: rtl/pwm10_interlock_chk.sv
module pwm10_interlock_chk #(
  parameter int HI_W = 8,
  parameter int LO_W = 2,
  localparam int CNT_W = HI_W + LO_W
) (
  input logic             clk,
  input logic             rst_n,
  input logic             tmr_wr,
  input logic [HI_W-1:0]  wr_data,
  input logic [HI_W-1:0]  per_act,
  input logic [CNT_W-1:0] duty_act,
  input logic [CNT_W-1:0] cnt,
  input logic             armed,
  input logic             roll,
  input logic             pwm_out
);
  // R2
  count_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!roll && !tmr_wr) |=> (cnt == $past(cnt) + 1'b1));
  // R2
  wrap_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    roll |=> (cnt == '0));
  // R3
  zero_duty_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (duty_act == '0) |-> !pwm_out);
  // R4
  duty_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !roll |=> $stable(duty_act));
  // R5
  period_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !roll |=> $stable(per_act));
  // R6
  early_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tmr_wr && wr_data == per_act) |=> (cnt == '0));
  // R7
  armed_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (armed && roll) |=> $stable(duty_act));
endmodule

bind pwm10_interlock pwm10_interlock_chk #(.HI_W(HI_W), .LO_W(LO_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .tmr_wr(tmr_wr), .wr_data(wr_data),
  .per_act(per_act), .duty_act(duty_act), .cnt(cnt), .armed(armed),
  .roll(roll), .pwm_out(pwm_out)
);

// File: tb/pwm10_interlock_tb.sv
module pwm10_interlock_tb;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       wr_en = 1'b0;
  logic [1:0] wr_sel = 2'd0;
  logic [7:0] wr_data = 8'd0;
  logic       pwm_out;

  int tests = 0;
  int fails = 0;
  string cur_req = "R1";

  // behavioural reference state
  int m_cnt, m_pact, m_ppend, m_hi, m_lo, m_dact, m_armed, m_lofirst;
  bit corner_on = 1'b0;
  int hi_run = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  pwm10_interlock u_dut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(wr_sel),
    .wr_data(wr_data), .pwm_out(pwm_out)
  );

  always @(posedge clk) begin
    if (!rst_n) begin
      m_cnt = 0; m_pact = 0; m_ppend = 0; m_hi = 0; m_lo = 0;
      m_dact = 0; m_armed = 0; m_lofirst = 0;
    end else begin
      bit ro, tw;
      int arm0, lf0;
      tw = wr_en && wr_sel == 2'd3;
      ro = tw ? (int'(wr_data) == m_pact) : (m_cnt == m_pact * 4 + 3);
      arm0 = m_armed; lf0 = m_lofirst;
      if (ro) begin
        m_cnt = 0;
        m_pact = m_ppend;
        if (arm0 == 0) m_dact = m_hi * 4 + m_lo;
        m_lofirst = 0;
      end else if (tw) m_cnt = int'(wr_data) * 4;
      else m_cnt = m_cnt + 1;
      if (wr_en && wr_sel == 2'd0) m_ppend = int'(wr_data);
      if (wr_en && wr_sel == 2'd1) begin
        m_hi = int'(wr_data);
        if (lf0 != 0) m_lofirst = 0; else m_armed = 1;
      end
      if (wr_en && wr_sel == 2'd2) begin
        m_lo = int'(wr_data) % 4;
        if (arm0 != 0) m_armed = 0; else m_lofirst = 1;
      end
    end
  end

  // compare every clock, away from the active edge
  always @(negedge clk) begin
    if (!done) begin
      bit exp_o;
      exp_o = rst_n ? (m_cnt < m_dact) : 1'b0;
      tests++;
      if (pwm_out !== exp_o) begin
        fails++;
        $display("FAIL %s: pwm_out=%0b expected %0b (cnt=%0d duty=%0d)",
                 cur_req, pwm_out, exp_o, m_cnt, m_dact);
      end
      if (corner_on && m_cnt == 0) begin
        tests++;
        // R9: a torn duty would give 7 or 0 high clocks
        if (hi_run != 3 && hi_run != 4) begin
          fails++;
          $display("FAIL R9: high clocks per cycle=%0d expected 3 or 4", hi_run);
        end
      end
      if (m_cnt == 0) hi_run = 0;
      if (pwm_out === 1'b1) hi_run++;
    end
  end

  task automatic wr(input logic [1:0] s, input int d);
    wr_en = 1'b1; wr_sel = s; wr_data = 8'(d);
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic summary();
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    done = 1'b1;
    fails++;
    $display("FAIL watchdog: run did not end, expected completion");
    summary();
  end

  initial begin
    cur_req = "R1";
    idle(5);
    @(posedge clk); #1 rst_n = 1'b1;
    @(negedge clk);
    cur_req = "R2"; idle(10);
    cur_req = "R3";
    wr(2'd0, 3); wr(2'd1, 1); wr(2'd2, 2); idle(40);
    cur_req = "R4";
    idle(5); wr(2'd1, 2); wr(2'd2, 1); idle(40);
    cur_req = "R3";
    wr(2'd1, 4); wr(2'd2, 0); idle(40);
    wr(2'd1, 9); wr(2'd2, 3); idle(40);
    wr(2'd1, 0); wr(2'd2, 0); idle(40);
    cur_req = "R5";
    wr(2'd0, 1); wr(2'd1, 1); wr(2'd2, 1); idle(30);
    wr(2'd0, 2); idle(40);
    cur_req = "R6";
    idle(3); wr(2'd3, 2); idle(20);
    wr(2'd3, 1); idle(20);
    wr(2'd3, 0); idle(20);
    cur_req = "R7";
    wr(2'd1, 2); idle(50); wr(2'd2, 3); idle(30);
    cur_req = "R8";
    wr(2'd2, 1); wr(2'd1, 0); idle(30);
    wr(2'd2, 2); idle(40); wr(2'd1, 1); idle(30); wr(2'd2, 0); idle(30);
    cur_req = "R9";
    wr(2'd0, 3); wr(2'd1, 1); wr(2'd2, 0); idle(40);
    corner_on = 1'b1;
    for (int i = 0; i < 48; i++) begin
      idle((i * 5) % 16);
      if (i % 2 == 0) begin wr(2'd1, 0); wr(2'd2, 3); end
      else            begin wr(2'd1, 1); wr(2'd2, 0); end
    end
    idle(20);
    corner_on = 1'b0;
    done = 1'b1;
    summary();
  end
endmodule